// File: doc/BRIEF.md
# Recent Result Window with Magnitude Extremes

This block keeps a sliding window of the most recent signed decimal results taken from a running count. A result is a sign bit over a field of BCD digits, most significant digit first. Each store strobe copies the live value into the window and pushes out the oldest entry. A clear strobe empties the window.

From the entries that hold data, the block finds the one with the smallest magnitude and the one with the largest. The sign plays no part in either comparison. One output shows one of four views, picked by a 2-bit select: the live value, the newest stored entry, the smallest-magnitude entry or the largest-magnitude entry. The views that come from the window are combinational over its registers, so a new store shows on the output in the first cycle after the strobe edge. The default build has three digits and a four-entry window, which gives 13-bit results.

Top module: `rwt_tracker`

## Requirements
- R1: After reset the window is empty. Select values 1, 2 and 3 all show 13'h0000.
- R2: With select 0 the output equals `live_val` in the same cycle, whether or not anything is stored.
- R3: With select 1 the output is the value that `live_val` held at the most recent accepted store edge. It shows from the cycle after that edge onward.
- R4: The window holds at most four entries. A store into a full window drops the oldest entry, and that entry no longer takes part in the minimum or maximum.
- R5: With select 2 the output is the stored entry whose magnitude is smallest. Bit 12 is the sign (1 = negative) and is ignored. Bits 11:0 are three BCD digits, most significant first, and are compared as an unsigned number.
- R6: With select 3 the output is the stored entry whose magnitude is largest, using the same magnitude rule as R5.
- R7: When stored entries tie on magnitude, the minimum and maximum views report the newest of them, including its sign bit.
- R8: A clear strobe empties the window, so views 1, 2 and 3 show zero afterwards. A store that arrives in the same cycle as a clear is dropped.
- R9: Only slots that hold data are compared. A partly filled window never reports zero as an extreme unless a zero was actually stored.
- R10: The views from the window change only in the cycle after an accepted store or clear edge and hold steady otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_val | input | 13 | Running signed BCD value, sign in the MSB |
| push | input | 1 | Store strobe: capture `live_val` into the window |
| flush | input | 1 | Clear strobe: empty the window (wins over `push`) |
| view_sel | input | 2 | 0 live, 1 newest stored, 2 smallest magnitude, 3 largest magnitude |
| view_out | output | 13 | Selected view |

## Verification
The bench builds the block with its default parameters: three digits and a four-entry window. These values make eviction reachable after only five stores, and they let every magnitude be written as readable hex digits. The sequences place negative entries with large magnitudes next to small positive ones, so any comparison that looks at the sign shows up. They also evict the current minimum, store equal magnitudes with opposite signs, store a real zero into a partly filled window, and raise store and clear in the same cycle.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

  // Output view encoding (fixed by the select input).
  typedef enum logic [1:0] {
    VIEW_LIVE = 2'd0,
    VIEW_LAST = 2'd1,
    VIEW_MIN  = 2'd2,
    VIEW_MAX  = 2'd3
  } view_e;

  // Which extreme a selector stage tracks.
  typedef enum logic {
    PICK_SMALLEST = 1'b0,
    PICK_LARGEST  = 1'b1
  } pick_e;

  localparam int unsigned DIGITS_DEF = 3;
  localparam int unsigned DEPTH_DEF  = 4;

endpackage

// File: rtl/rwt_window.sv
module rwt_window #(
  parameter int unsigned DIGITS = rwt_pkg::DIGITS_DEF,
  parameter int unsigned DEPTH  = rwt_pkg::DEPTH_DEF,
  localparam int unsigned RES_W = 1 + 4 * DIGITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RES_W-1:0]             in_val,
  input  logic                         push,
  input  logic                         flush,
  output logic [DEPTH-1:0][RES_W-1:0]  slot_data,
  output logic [DEPTH-1:0]             slot_vld
);

  // Slot 0 is the newest entry; slot DEPTH-1 the oldest.
  logic accept;
  assign accept = push && !flush;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [RES_W-1:0] nxt_data;
    logic             nxt_vld;
    if (s == 0) begin : g_head
      assign nxt_data = in_val;
      assign nxt_vld  = 1'b1;
    end else begin : g_body
      assign nxt_data = slot_data[s-1];
      assign nxt_vld  = slot_vld[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[s] <= '0;
        slot_vld[s]  <= 1'b0;
      end else if (flush) begin
        slot_data[s] <= '0;
        slot_vld[s]  <= 1'b0;
      end else if (accept) begin
        slot_data[s] <= nxt_data;
        slot_vld[s]  <= nxt_vld;
      end
    end
  end

endmodule

// File: rtl/rwt_extreme.sv
module rwt_extreme #(
  parameter int unsigned   DIGITS = rwt_pkg::DIGITS_DEF,
  parameter int unsigned   DEPTH  = rwt_pkg::DEPTH_DEF,
  parameter rwt_pkg::pick_e MODE  = rwt_pkg::PICK_SMALLEST,
  localparam int unsigned  RES_W  = 1 + 4 * DIGITS,
  localparam int unsigned  MAG_W  = 4 * DIGITS
) (
  input  logic [DEPTH-1:0][RES_W-1:0] slot_data,
  input  logic [DEPTH-1:0]            slot_vld,
  output logic [RES_W-1:0]            best
);

  // Magnitude: BCD digits MSD first compare correctly as unsigned.
  function automatic logic [MAG_W-1:0] mag_of(input logic [RES_W-1:0] v);
    return v[MAG_W-1:0];
  endfunction

  // Candidate a displaces b when it is at least as extreme (ties go to a).
  function automatic logic beats(input logic [RES_W-1:0] a,
                                 input logic [RES_W-1:0] b);
    if (MODE == rwt_pkg::PICK_LARGEST) return mag_of(a) >= mag_of(b);
    else                               return mag_of(a) <= mag_of(b);
  endfunction

  logic [RES_W-1:0] run_val [DEPTH+1];
  logic             run_ok  [DEPTH+1];

  assign run_val[0] = '0;
  assign run_ok[0]  = 1'b0;

  // Walk from oldest to newest so the newest wins any tie.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    localparam int unsigned IDX = DEPTH - 1 - k;
    logic take;
    assign take = slot_vld[IDX] && (!run_ok[k] || beats(slot_data[IDX], run_val[k]));
    assign run_val[k+1] = take ? slot_data[IDX] : run_val[k];
    assign run_ok[k+1]  = run_ok[k] | slot_vld[IDX];
  end

  assign best = run_val[DEPTH];

endmodule

// File: rtl/rwt_view_mux.sv
module rwt_view_mux #(
  parameter int unsigned RES_W = 13
) (
  input  logic [1:0]       view_sel,
  input  logic [RES_W-1:0] live_val,
  input  logic [RES_W-1:0] last_val,
  input  logic [RES_W-1:0] min_val,
  input  logic [RES_W-1:0] max_val,
  output logic [RES_W-1:0] view_out
);
  import rwt_pkg::*;

  always_comb begin
    unique case (view_e'(view_sel))
      VIEW_LIVE: view_out = live_val;
      VIEW_LAST: view_out = last_val;
      VIEW_MIN:  view_out = min_val;
      VIEW_MAX:  view_out = max_val;
      default:   view_out = live_val;
    endcase
  end

endmodule

// File: rtl/rwt_tracker.sv
module rwt_tracker #(
  parameter int unsigned DIGITS = rwt_pkg::DIGITS_DEF,
  parameter int unsigned DEPTH  = rwt_pkg::DEPTH_DEF,
  localparam int unsigned RES_W = 1 + 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] live_val,
  input  logic             push,
  input  logic             flush,
  input  logic [1:0]       view_sel,
  output logic [RES_W-1:0] view_out
);

  logic [DEPTH-1:0][RES_W-1:0] slot_data;
  logic [DEPTH-1:0]            slot_vld;
  logic [RES_W-1:0]            last_val;
  logic [RES_W-1:0]            min_val;
  logic [RES_W-1:0]            max_val;

  rwt_window #(.DIGITS(DIGITS), .DEPTH(DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .in_val(live_val), .push(push), .flush(flush),
    .slot_data(slot_data), .slot_vld(slot_vld)
  );

  assign last_val = slot_vld[0] ? slot_data[0] : '0;

  rwt_extreme #(.DIGITS(DIGITS), .DEPTH(DEPTH), .MODE(rwt_pkg::PICK_SMALLEST)) u_min (
    .slot_data(slot_data), .slot_vld(slot_vld), .best(min_val)
  );

  rwt_extreme #(.DIGITS(DIGITS), .DEPTH(DEPTH), .MODE(rwt_pkg::PICK_LARGEST)) u_max (
    .slot_data(slot_data), .slot_vld(slot_vld), .best(max_val)
  );

  rwt_view_mux #(.RES_W(RES_W)) u_mux (
    .view_sel(view_sel), .live_val(live_val), .last_val(last_val),
    .min_val(min_val), .max_val(max_val), .view_out(view_out)
  );

endmodule

// File: rtl/rwt_checker.sv
module rwt_checker #(
  parameter int unsigned DIGITS = rwt_pkg::DIGITS_DEF,
  parameter int unsigned DEPTH  = rwt_pkg::DEPTH_DEF,
  localparam int unsigned RES_W = 1 + 4 * DIGITS,
  localparam int unsigned MAG_W = 4 * DIGITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] live_val,
  input logic             push,
  input logic             flush,
  input logic [1:0]       view_sel,
  input logic [RES_W-1:0] view_out,
  input logic [DEPTH-1:0] slot_vld,
  input logic [RES_W-1:0] last_val,
  input logic [RES_W-1:0] min_val,
  input logic [RES_W-1:0] max_val
);

  // R2: live view passes through.
  p_live_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    view_sel == 2'd0 |-> view_out == live_val);

  // R3: newest view follows the accepted store.
  p_last_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(push && !flush) |-> last_val == $past(live_val));

  // R4: occupancy shifts in one entry per accepted store.
  p_fill_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(push && !flush) |-> slot_vld == {$past(slot_vld[DEPTH-2:0]), 1'b1});

  // R5/R6: the smallest magnitude never exceeds the largest.
  p_min_le_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |slot_vld |-> min_val[MAG_W-1:0] <= max_val[MAG_W-1:0]);

  // R8: clear empties the window.
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> slot_vld == '0);

  // R1/R9: an empty window shows zero on every stored view.
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld == '0 |-> (last_val == '0 && min_val == '0 && max_val == '0));

  // R10: without strobes the stored views hold.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(push) && !$past(flush) |->
      $stable(slot_vld) && $stable(last_val) && $stable(min_val) && $stable(max_val));

endmodule

bind rwt_tracker rwt_checker #(.DIGITS(DIGITS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .live_val(live_val), .push(push), .flush(flush),
  .view_sel(view_sel), .view_out(view_out), .slot_vld(slot_vld),
  .last_val(last_val), .min_val(min_val), .max_val(max_val)
);

// File: tb/sim_rwt_tracker.sv
module sim_rwt_tracker;

  localparam int CLK_NS = 10;
  localparam int W = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] live_val = '0;
  logic         push = 1'b0;
  logic         flush = 1'b0;
  logic [1:0]   view_sel = 2'd0;
  logic [W-1:0] view_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rwt_tracker u0 (
    .clk(clk), .rst_n(rst_n), .live_val(live_val), .push(push), .flush(flush),
    .view_sel(view_sel), .view_out(view_out)
  );

  // Sign in bit 12 (1 = negative), three BCD digits below.
  function automatic logic [W-1:0] val(input bit neg, input logic [11:0] digits);
    return {neg, digits};
  endfunction

  task automatic check_view(input logic [1:0] sel, input logic [W-1:0] exp, input string req);
    view_sel = sel;
    #1;
    n_checks++;
    if (view_out !== exp) begin
      n_fails++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, view_out, exp);
    end
  endtask

  task automatic store(input logic [W-1:0] v);
    @(negedge clk);
    live_val = v;
    push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check_view(2'd1, '0, "R1");
    check_view(2'd2, '0, "R1");
    check_view(2'd3, '0, "R1");
  endtask

  task automatic t_live();
    live_val = val(1, 12'h999);
    check_view(2'd0, val(1, 12'h999), "R2");
    live_val = val(0, 12'h001);
    check_view(2'd0, val(0, 12'h001), "R2");
  endtask

  task automatic t_single();
    store(val(0, 12'h700));
    // first cycle after the store edge (R10)
    check_view(2'd1, val(0, 12'h700), "R3");
    check_view(2'd2, val(0, 12'h700), "R9");
    check_view(2'd3, val(0, 12'h700), "R10");
  endtask

  task automatic t_fill_evict();
    store(val(1, 12'h325));
    store(val(0, 12'h040));
    store(val(1, 12'h910));
    check_view(2'd2, val(0, 12'h040), "R5");
    check_view(2'd3, val(1, 12'h910), "R6");
    store(val(0, 12'h200));   // drops +7.00
    check_view(2'd1, val(0, 12'h200), "R3");
    check_view(2'd3, val(1, 12'h910), "R6");
    store(val(0, 12'h500));
    store(val(0, 12'h600));
    store(val(0, 12'h800));   // window: 800 600 500 200
    check_view(2'd2, val(0, 12'h200), "R4");
    check_view(2'd3, val(0, 12'h800), "R4");
    store(val(0, 12'h900));   // drops 200
    check_view(2'd2, val(0, 12'h500), "R4");
    live_val = val(0, 12'h123);
    check_view(2'd1, val(0, 12'h900), "R10");
  endtask

  task automatic t_ties();
    clear_all();
    store(val(0, 12'h500));
    store(val(1, 12'h500));
    check_view(2'd2, val(1, 12'h500), "R7");
    check_view(2'd3, val(1, 12'h500), "R7");
    store(val(0, 12'h500));
    check_view(2'd2, val(0, 12'h500), "R7");
  endtask

  task automatic t_zero_entry();
    clear_all();
    store(val(0, 12'h000));
    store(val(1, 12'h300));
    check_view(2'd2, val(0, 12'h000), "R9");
    check_view(2'd3, val(1, 12'h300), "R9");
  endtask

  task automatic t_clear();
    store(val(1, 12'h450));
    clear_all();
    check_view(2'd1, '0, "R8");
    check_view(2'd2, '0, "R8");
    check_view(2'd3, '0, "R8");
    @(negedge clk);
    live_val = val(0, 12'h777);
    push = 1'b1;
    flush = 1'b1;
    @(negedge clk);
    push = 1'b0;
    flush = 1'b0;
    check_view(2'd1, '0, "R8");
    check_view(2'd3, '0, "R8");
    store(val(0, 12'h321));
    check_view(2'd2, val(0, 12'h321), "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_live();
    t_single();
    t_fill_evict();
    t_ties();
    t_zero_entry();
    t_clear();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule